// File: doc/BRIEF.md
# Target Receive Byte Buffer

This block sits between the bus engine of a serial bus target and the host. Bytes that the bus engine takes off the wire go into a 16-entry queue. The queue automatically fills a single host-visible holding register. The host sees one byte at a time together with a "byte ready" bit. That bit also serves as the interrupt and DMA request line. Each host read strobe consumes the byte in the holding register. If more bytes are queued, the next one replaces it in the same cycle, so a reader that strobes every cycle sees no gap.

Two error conditions are recorded in sticky flags that the host clears by writing ones:
- A read error: the host strobes a read while nothing is ready.
- An overrun: the bus engine pushes a byte while the queue is full.

When the overrun happens in I2C mode, the block tells the bus engine, in the same cycle, to NACK the write. A flush command discards everything that has been received and not yet read.

Top module: `tgt_rx_buffer`

## Requirements
- R1: After reset, `host_full`, `host_data`, `rd_err`, `ovr_err` and `bus_nack` are all 0.
- R2: A byte pushed while the queue is empty and the holding register is free (empty, or read in that same cycle) goes straight into the holding register. `host_full` is 1 and `host_data` shows the byte from the cycle after the push.
- R3: A host read while `host_full` is 1 consumes the byte. If no further byte is waiting, `host_full` is 0 from the next cycle. `host_data` keeps its old value until the next refill.
- R4: A host read while bytes wait in the queue loads the oldest waiting byte in the same cycle. `host_full` stays 1 with no empty cycle, and bytes reach `host_data` in arrival order.
- R5: A host read while `host_full` is 0 sets `rd_err`. It leaves `host_data`, `host_full` and the queue unchanged.
- R6: The queue stores 16 bytes behind the holding register, 17 in all. A push while 16 bytes are queued sets `ovr_err`. That byte is dropped, and the stored bytes are unchanged. A push is refused whenever the queue is full at the start of the cycle, even if a byte leaves it in that cycle.
- R7: `bus_nack` is 1, in the same cycle, exactly when an overrunning push arrives while `i2c_mode` is 1. It is 0 otherwise, including for an overrun with `i2c_mode` 0.
- R8: `flush` empties the queue and the holding register. `host_full` is 0 and `host_data` is 0 from the next cycle. A push in a flush cycle is discarded and raises no overrun.
- R9: `err_clr` is write-one-to-clear: bit 0 clears `rd_err` and bit 1 clears `ovr_err`. A set event in the same cycle as the clear wins, so the flag stays 1.

Port order in the table below matches the port list of `tgt_rx_buffer`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_push | input | 1 | Bus engine presents a received byte this cycle |
| bus_byte | input | 8 | Received byte |
| i2c_mode | input | 1 | Bus is running in I2C mode (overrun must be NACKed) |
| bus_nack | output | 1 | NACK the current byte (combinational) |
| host_rd | input | 1 | Host read strobe for the holding register |
| host_data | output | 8 | Holding register contents |
| host_full | output | 1 | Holding register holds an unread byte; interrupt/DMA request |
| flush | input | 1 | Discard all received, unread data |
| err_clr | input | 2 | Write-one-to-clear pulse: bit 0 read error, bit 1 overrun |
| rd_err | output | 1 | Sticky read-error flag |
| ovr_err | output | 1 | Sticky overrun flag |

## Verification
`bus_nack` is combinational. It is due in the same cycle as the overrunning push, so the bench samples it after driving inputs and before the next rising edge. Every other result is due one edge after its stimulus: the holding register, `host_full`, the queue and both flags are each one register stage from the inputs. The bench drives on the falling edge and samples one nanosecond after the following rising edge. The back-to-back drain checks `host_data` and `host_full` before each read strobe, so each value seen is the one produced by the previous edge.

// File: rtl/tgt_rxb_pkg.sv
package tgt_rxb_pkg;
    localparam int BYTE_W = 8;
    localparam int N_ERR  = 2;
    localparam int ERR_RD  = 0;
    localparam int ERR_OVR = 1;
    typedef logic [BYTE_W-1:0] rx_byte_t;
endpackage

// File: rtl/rxb_fifo.sv
module rxb_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wr;
        logic [AW-1:0]               rd;
        logic [CW-1:0]               cnt;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic push_ok, pop_ok;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == CW'(DEPTH));
    assign head  = s_q.mem[s_q.rd];
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d.wr  = '0;
            s_d.rd  = '0;
            s_d.cnt = '0;
        end else begin
            if (push_ok) begin
                s_d.mem[s_q.wr] = push_data;
                s_d.wr          = ptr_next(s_q.wr);
            end
            if (pop_ok) begin
                s_d.rd = ptr_next(s_q.rd);
            end
            case ({push_ok, pop_ok})
                2'b10:   s_d.cnt = s_q.cnt + CW'(1);
                2'b01:   s_d.cnt = s_q.cnt - CW'(1);
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/rxb_hold.sv
module rxb_hold #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             load,
    input  logic [WIDTH-1:0] load_data,
    input  logic             consume,
    output logic [WIDTH-1:0] data,
    output logic             full
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             full;
    } hold_state_t;

    hold_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d.data = '0;
            s_d.full = 1'b0;
        end else if (load) begin
            s_d.data = load_data;
            s_d.full = 1'b1;
        end else if (consume) begin
            s_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign data = s_q.data;
    assign full = s_q.full;
endmodule

// File: rtl/rxb_sticky.sv
module rxb_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    logic [N-1:0] flags_d, flags_q;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            flags_d[i] = set[i] | (flags_q[i] & ~clr[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/tgt_rx_buffer.sv
module tgt_rx_buffer
    import tgt_rxb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_push,
    input  logic [BYTE_W-1:0] bus_byte,
    input  logic              i2c_mode,
    output logic              bus_nack,
    input  logic              host_rd,
    output logic [BYTE_W-1:0] host_data,
    output logic              host_full,
    input  logic              flush,
    input  logic [N_ERR-1:0]  err_clr,
    output logic              rd_err,
    output logic              ovr_err
);
    typedef struct packed {
        logic     rd_ok;
        logic     rd_bad;
        logic     from_q;
        logic     direct;
        logic     refill;
        rx_byte_t refill_data;
        logic     q_push;
        logic     overrun;
    } ctl_t;

    ctl_t             ctl;
    rx_byte_t         q_head;
    logic             fifo_empty, fifo_full;
    logic [N_ERR-1:0] err_set, err_flags;

    always_comb begin
        ctl             = '0;
        ctl.rd_ok       = host_rd && host_full;
        ctl.rd_bad      = host_rd && !host_full;
        ctl.from_q      = !flush && (!host_full || ctl.rd_ok) && !fifo_empty;
        ctl.direct      = !flush && (!host_full || ctl.rd_ok) && fifo_empty && bus_push;
        ctl.refill      = ctl.from_q || ctl.direct;
        ctl.refill_data = ctl.from_q ? q_head : bus_byte;
        ctl.overrun     = !flush && bus_push && fifo_full;
        ctl.q_push      = !flush && bus_push && !fifo_full && !ctl.direct;
        err_set          = '0;
        err_set[ERR_RD]  = ctl.rd_bad;
        err_set[ERR_OVR] = ctl.overrun;
    end

    assign bus_nack = ctl.overrun && i2c_mode;

    rxb_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (ctl.q_push),
        .push_data (bus_byte),
        .pop       (ctl.from_q),
        .head      (q_head),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    rxb_hold #(.WIDTH(BYTE_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .load      (ctl.refill),
        .load_data (ctl.refill_data),
        .consume   (ctl.rd_ok),
        .data      (host_data),
        .full      (host_full)
    );

    rxb_sticky #(.N(N_ERR)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (err_set),
        .clr   (err_clr),
        .flags (err_flags)
    );

    assign rd_err  = err_flags[ERR_RD];
    assign ovr_err = err_flags[ERR_OVR];
endmodule

// File: rtl/tgt_rx_buffer_checker.sv
module tgt_rx_buffer_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_push,
    input logic       i2c_mode,
    input logic       bus_nack,
    input logic       host_rd,
    input logic [7:0] host_data,
    input logic       host_full,
    input logic       flush,
    input logic [1:0] err_clr,
    input logic       rd_err,
    input logic       ovr_err,
    input logic       fifo_empty,
    input logic       fifo_full
);
    p_drain_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && host_full && fifo_empty && !bus_push && !flush |=> !host_full);

    p_no_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && host_full && !fifo_empty && !flush |=> host_full);

    p_read_error_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && !host_full |=> rd_err);

    p_read_error_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && !host_full && fifo_empty && !bus_push && !flush |=> $stable(host_data) && !host_full);

    p_overrun_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_push && fifo_full && !flush |=> ovr_err);

    p_nack_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_nack |-> (bus_push && i2c_mode && fifo_full));

    p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !host_full && host_data == 8'h00);

    p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_err && !err_clr[1] |=> ovr_err);
endmodule

bind tgt_rx_buffer tgt_rx_buffer_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_push   (bus_push),
    .i2c_mode   (i2c_mode),
    .bus_nack   (bus_nack),
    .host_rd    (host_rd),
    .host_data  (host_data),
    .host_full  (host_full),
    .flush      (flush),
    .err_clr    (err_clr),
    .rd_err     (rd_err),
    .ovr_err    (ovr_err),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full)
);

// File: tb/tgt_rx_buffer_bench.sv
`timescale 1ns/100ps
module tgt_rx_buffer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_push = 1'b0;
    logic [7:0] bus_byte = '0;
    logic       i2c_mode = 1'b0;
    logic       bus_nack;
    logic       host_rd = 1'b0;
    logic [7:0] host_data;
    logic       host_full;
    logic       flush = 1'b0;
    logic [1:0] err_clr = '0;
    logic       rd_err, ovr_err;
    logic       nack_seen;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tgt_rx_buffer u_tgt_rx_buffer (
        .clk(clk), .rst_n(rst_n), .bus_push(bus_push), .bus_byte(bus_byte),
        .i2c_mode(i2c_mode), .bus_nack(bus_nack), .host_rd(host_rd),
        .host_data(host_data), .host_full(host_full), .flush(flush),
        .err_clr(err_clr), .rd_err(rd_err), .ovr_err(ovr_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive on falling edge, capture nack before the rising edge,
    // return 1 ns after the rising edge with registered results settled.
    task automatic cyc(input bit push, input logic [7:0] b, input bit rd,
                       input bit fl, input logic [1:0] ec);
        @(negedge clk);
        bus_push = push; bus_byte = b; host_rd = rd; flush = fl; err_clr = ec;
        #1 nack_seen = bus_nack;
        @(posedge clk);
        #1;
        bus_push = 1'b0; host_rd = 1'b0; flush = 1'b0; err_clr = '0;
    endtask

    task automatic t_reset();
        chk("R1 full", int'(host_full), 0);
        chk("R1 data", int'(host_data), 0);
        chk("R1 rd_err", int'(rd_err), 0);
        chk("R1 ovr_err", int'(ovr_err), 0);
        chk("R1 nack", int'(bus_nack), 0);
    endtask

    task automatic t_single();
        cyc(1, 8'hA5, 0, 0, 2'b00);
        chk("R2 full after push", int'(host_full), 1);
        chk("R2 data after push", int'(host_data), 'hA5);
        cyc(0, 8'h00, 1, 0, 2'b00);
        chk("R3 full after read", int'(host_full), 0);
        chk("R3 data kept", int'(host_data), 'hA5);
    endtask

    task automatic t_read_error();
        cyc(0, 8'h00, 1, 0, 2'b00);
        chk("R5 rd_err set", int'(rd_err), 1);
        chk("R5 data unchanged", int'(host_data), 'hA5);
        chk("R5 full unchanged", int'(host_full), 0);
        cyc(0, 8'h00, 0, 0, 2'b01);
        chk("R9 rd_err cleared", int'(rd_err), 0);
    endtask

    task automatic fill17(input logic [7:0] base);
        for (int i = 0; i < 17; i++) cyc(1, base + 8'(i), 0, 0, 2'b00);
    endtask

    task automatic t_overrun_drain();
        i2c_mode = 1'b0;
        fill17(8'h10);
        chk("R6 no overrun at 17", int'(ovr_err), 0);
        i2c_mode = 1'b1;
        cyc(1, 8'hEE, 0, 0, 2'b00);
        chk("R7 nack in i2c", int'(nack_seen), 1);
        chk("R6 overrun flag", int'(ovr_err), 1);
        i2c_mode = 1'b0;
        cyc(1, 8'hEF, 0, 0, 2'b00);
        chk("R7 no nack outside i2c", int'(nack_seen), 0);
        for (int i = 0; i < 17; i++) begin
            chk("R4 full while draining", int'(host_full), 1);
            chk("R4 order", int'(host_data), 'h10 + i);
            cyc(0, 8'h00, 1, 0, 2'b00);
        end
        chk("R6 overrun byte dropped", int'(host_full), 0);
        cyc(0, 8'h00, 0, 0, 2'b10);
        chk("R9 ovr cleared", int'(ovr_err), 0);
    endtask

    task automatic t_priority_flush();
        fill17(8'h40);
        cyc(1, 8'h99, 0, 0, 2'b10);
        chk("R9 set wins over clear", int'(ovr_err), 1);
        cyc(0, 8'h00, 0, 0, 2'b10);
        chk("R9 clear alone", int'(ovr_err), 0);
        cyc(1, 8'h77, 0, 1, 2'b00);
        chk("R8 full after flush", int'(host_full), 0);
        chk("R8 data after flush", int'(host_data), 0);
        chk("R8 no overrun in flush", int'(ovr_err), 0);
        cyc(0, 8'h00, 1, 0, 2'b00);
        chk("R8 holding empty", int'(rd_err), 1);
        cyc(0, 8'h00, 0, 0, 2'b01);
        cyc(1, 8'h5C, 0, 0, 2'b00);
        chk("R8 queue empty, new byte first", int'(host_data), 'h5C);
        cyc(0, 8'h00, 1, 0, 2'b00);
        chk("R8 no stale bytes", int'(host_full), 0);
    endtask

    task automatic t_same_cycle();
        cyc(1, 8'h01, 0, 0, 2'b00);
        cyc(1, 8'h02, 1, 0, 2'b00);
        chk("R2 direct refill on read", int'(host_full), 1);
        chk("R2 direct refill data", int'(host_data), 'h02);
        cyc(0, 8'h00, 1, 0, 2'b00);
        chk("R3 empty after last read", int'(host_full), 0);
        chk("R5 no spurious rd_err", int'(rd_err), 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                #1 t_reset();
                @(negedge clk) rst_n = 1'b1;
                @(posedge clk); #1;
                t_reset();
                t_single();
                t_read_error();
                t_overrun_drain();
                t_priority_flush();
                t_same_cycle();
                done = 1'b1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    checks++; failures++;
                    $display("FAIL watchdog actual=timeout expected=done");
                end
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule